// File: doc/BRIEF.md
# Single Load/Store Address Generator

This block turns the addressing fields of one single-register load or store into the effective memory address. It also produces the value to write back into the base register. The caller supplies, in the same cycle as `in_valid`, the base register value, the offset register value, the carry flag and the decoded control and shift fields. One cycle later the block returns the address, a writeback request with its value, and an annul flag for register combinations that must not execute.

The offset comes from one of four sources:

- a 12-bit immediate (word form);
- an offset register passed through an immediate-amount shifter (word form);
- an 8-bit immediate split into two 4-bit fields (halfword form);
- the plain offset register (halfword form).

The control bits select the addressing:

- The pre bit and the writeback bit select offset, pre-indexed or post-indexed addressing.
- The up bit chooses whether the offset is added or subtracted.

The block does no memory access and no alignment check.

Top module: `ls_addr_gen`

## Requirements
- R1: With `p_bit`=1 and `w_bit`=0 (offset mode), `addr` is base plus or minus offset and `wb_en` is 0.
- R2: With `p_bit`=1 and `w_bit`=1 (pre-indexed), `addr` is base plus or minus offset, `wb_en` is 1 and `wb_val` equals `addr`.
- R3: With `p_bit`=0 (post-indexed), `addr` equals the base, `wb_en` is 1 and `wb_val` is base plus or minus offset. In word form this holds whatever the value of `w_bit`.
- R4: `u_bit`=1 adds the offset and `u_bit`=0 subtracts it.
- R5: In offset mode with `rn_idx`=15, the base used is `base_val`+4.
- R6: Any writeback form (pre- or post-indexed) with `rn_idx`=15 or `rn_idx`=`rd_idx` is annulled.
- R7: A writeback form that uses a register offset (`use_reg`=1) is also annulled when `rm_idx`=15 or `rn_idx`=`rm_idx`.
- R8: In word form with `use_reg`=1, the offset is `rm_val` shifted by `sh_amt` (1..31). The shift kind is set by `sh_type`: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right.
- R9: With `sh_amt`=0 the shift kinds take these results:
  - logical left passes `rm_val` unchanged;
  - logical right gives 0;
  - arithmetic right gives 32 copies of `rm_val[31]`;
  - rotate gives {`carry_in`, `rm_val[31:1]`}.
- R10: In halfword form (`half_form`=1), `use_reg`=0 gives the offset {`imm_hi`, `imm_lo`} zero-extended, and `use_reg`=1 gives `rm_val` unshifted.
- R11: In halfword form, `p_bit`=0 together with `w_bit`=1 is annulled.
- R12: An annulled instruction gives `annul`=1, `wb_en`=0, `addr`=0 and `wb_val`=0.
- R13: Results appear one cycle after `in_valid`, with `out_valid`=1. A cycle without `in_valid` gives `out_valid`=0 and leaves the other outputs unchanged.
- R14: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| half_form | input | 1 | 1 = halfword form, 0 = word form |
| use_reg | input | 1 | 1 = offset from register, 0 = immediate |
| p_bit | input | 1 | Pre (1) or post (0) indexing |
| u_bit | input | 1 | Add (1) or subtract (0) the offset |
| w_bit | input | 1 | Writeback bit |
| rn_idx | input | 4 | Base register index |
| rd_idx | input | 4 | Data register index |
| rm_idx | input | 4 | Offset register index |
| base_val | input | 32 | Base register value (PC already advanced) |
| rm_val | input | 32 | Offset register value |
| carry_in | input | 1 | Carry flag, used by rotate-with-extend |
| imm12 | input | 12 | Word-form immediate offset |
| sh_type | input | 2 | Shift kind for register offset |
| sh_amt | input | 5 | Immediate shift amount |
| imm_hi | input | 4 | Halfword immediate, upper field |
| imm_lo | input | 4 | Halfword immediate, lower field |
| out_valid | output | 1 | Result registers hold a new result |
| addr | output | 32 | Effective address |
| wb_en | output | 1 | Write `wb_val` to the base register |
| wb_val | output | 32 | Base register writeback value |
| annul | output | 1 | Instruction rejected |

## Verification
The index legality check and the writeback arithmetic act in the same cycle on the same instruction. The check must suppress the writeback that the arithmetic would request. The bench provokes this in three ways:

- pre- and post-indexed forms with a base index equal to 15, to the data index or to the offset index;
- the halfword post form with the writeback bit set;
- random vectors whose indices are drawn from a small range so that they collide often.

The rotate-with-extend path brings the carry flag and the shifter together in one cycle; both carry values are applied. A behavioural reference model judges every cycle's registered outputs, including the held values on idle cycles.

// File: rtl/ls_addr_pkg.sv
package ls_addr_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        AM_OFFSET = 2'd0,
        AM_PRE    = 2'd1,
        AM_POST   = 2'd2
    } addr_mode_e;

endpackage

// File: rtl/ls_index_shifter.sv
module ls_index_shifter
    import ls_addr_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  value,
    input  shift_kind_e   kind,
    input  logic [SW-1:0] amount,
    input  logic          carry,
    output logic [W-1:0]  result
);

    logic zero_amt;
    assign zero_amt = (amount == '0);

    always_comb begin
        unique case (kind)
            SH_LSL: result = value << amount;
            SH_LSR: result = zero_amt ? '0 : (value >> amount);
            SH_ASR: result = zero_amt ? {W{value[W-1]}}
                                      : $unsigned($signed(value) >>> amount);
            SH_ROR: result = zero_amt ? {carry, value[W-1:1]}
                                      : ((value >> amount) | (value << (W - int'(amount))));
            default: result = value;
        endcase
    end

endmodule

// File: rtl/ls_offset_pick.sv
module ls_offset_pick #(
    parameter int W     = 32,
    parameter int IMM_W = 12,
    parameter int NIB_W = 4
) (
    input  logic             half_form,
    input  logic             use_reg,
    input  logic [IMM_W-1:0] imm12,
    input  logic [NIB_W-1:0] imm_hi,
    input  logic [NIB_W-1:0] imm_lo,
    input  logic [W-1:0]     shifted,
    input  logic [W-1:0]     rm_val,
    output logic [W-1:0]     offset
);

    localparam int HALF_IMM_W = 2 * NIB_W;

    always_comb begin
        if (!half_form) begin
            offset = use_reg ? shifted : {{(W-IMM_W){1'b0}}, imm12};
        end else begin
            offset = use_reg ? rm_val : {{(W-HALF_IMM_W){1'b0}}, imm_hi, imm_lo};
        end
    end

endmodule

// File: rtl/ls_legal_check.sv
module ls_legal_check
    import ls_addr_pkg::*;
#(
    parameter int RIDX_W = 4,
    parameter int PC_IDX = 15
) (
    input  logic              half_form,
    input  logic              use_reg,
    input  logic              p_bit,
    input  logic              w_bit,
    input  logic [RIDX_W-1:0] rn_idx,
    input  logic [RIDX_W-1:0] rd_idx,
    input  logic [RIDX_W-1:0] rm_idx,
    output addr_mode_e        mode,
    output logic              reject
);

    localparam logic [RIDX_W-1:0] PC_CODE = RIDX_W'(PC_IDX);

    logic writes_base;
    logic base_clash;
    logic index_clash;
    logic half_bad;

    always_comb begin
        if (p_bit) begin
            mode = w_bit ? AM_PRE : AM_OFFSET;
        end else begin
            mode = AM_POST;
        end
        writes_base = (mode != AM_OFFSET);
        base_clash  = (rn_idx == PC_CODE) || (rn_idx == rd_idx);
        index_clash = use_reg && ((rm_idx == PC_CODE) || (rn_idx == rm_idx));
        half_bad    = half_form && !p_bit && w_bit;
        reject      = half_bad || (writes_base && (base_clash || index_clash));
    end

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
    import ls_addr_pkg::*;
#(
    parameter int W      = 32,
    parameter int RIDX_W = 4,
    parameter int IMM_W  = 12,
    parameter int NIB_W  = 4,
    parameter int PC_IDX = 15,
    parameter int PC_ADJ = 4,
    parameter int SW     = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              half_form,
    input  logic              use_reg,
    input  logic              p_bit,
    input  logic              u_bit,
    input  logic              w_bit,
    input  logic [RIDX_W-1:0] rn_idx,
    input  logic [RIDX_W-1:0] rd_idx,
    input  logic [RIDX_W-1:0] rm_idx,
    input  logic [W-1:0]      base_val,
    input  logic [W-1:0]      rm_val,
    input  logic              carry_in,
    input  logic [IMM_W-1:0]  imm12,
    input  logic [1:0]        sh_type,
    input  logic [SW-1:0]     sh_amt,
    input  logic [NIB_W-1:0]  imm_hi,
    input  logic [NIB_W-1:0]  imm_lo,
    output logic              out_valid,
    output logic [W-1:0]      addr,
    output logic              wb_en,
    output logic [W-1:0]      wb_val,
    output logic              annul
);

    localparam logic [RIDX_W-1:0] PC_CODE = RIDX_W'(PC_IDX);
    localparam logic [W-1:0]      PC_BUMP = W'(PC_ADJ);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] addr;
        logic         wb_en;
        logic [W-1:0] wb_val;
        logic         annul;
    } result_t;

    result_t    res_d, res_q;
    logic [W-1:0] shifted;
    logic [W-1:0] offset;
    logic [W-1:0] base_eff;
    logic [W-1:0] moved;
    addr_mode_e   mode;
    logic         reject;

    ls_index_shifter #(.W(W), .SW(SW)) u_shift (
        .value  (rm_val),
        .kind   (shift_kind_e'(sh_type)),
        .amount (sh_amt),
        .carry  (carry_in),
        .result (shifted)
    );

    ls_offset_pick #(.W(W), .IMM_W(IMM_W), .NIB_W(NIB_W)) u_pick (
        .half_form (half_form),
        .use_reg   (use_reg),
        .imm12     (imm12),
        .imm_hi    (imm_hi),
        .imm_lo    (imm_lo),
        .shifted   (shifted),
        .rm_val    (rm_val),
        .offset    (offset)
    );

    ls_legal_check #(.RIDX_W(RIDX_W), .PC_IDX(PC_IDX)) u_legal (
        .half_form (half_form),
        .use_reg   (use_reg),
        .p_bit     (p_bit),
        .w_bit     (w_bit),
        .rn_idx    (rn_idx),
        .rd_idx    (rd_idx),
        .rm_idx    (rm_idx),
        .mode      (mode),
        .reject    (reject)
    );

    always_comb begin
        base_eff = base_val;
        if ((mode == AM_OFFSET) && (rn_idx == PC_CODE)) begin
            base_eff = base_val + PC_BUMP;
        end
        moved = u_bit ? (base_eff + offset) : (base_eff - offset);

        res_d       = res_q;
        res_d.valid = 1'b0;
        if (in_valid) begin
            res_d.valid = 1'b1;
            if (reject) begin
                res_d.addr   = '0;
                res_d.wb_en  = 1'b0;
                res_d.wb_val = '0;
                res_d.annul  = 1'b1;
            end else begin
                res_d.annul = 1'b0;
                unique case (mode)
                    AM_OFFSET: begin
                        res_d.addr   = moved;
                        res_d.wb_en  = 1'b0;
                        res_d.wb_val = '0;
                    end
                    AM_PRE: begin
                        res_d.addr   = moved;
                        res_d.wb_en  = 1'b1;
                        res_d.wb_val = moved;
                    end
                    default: begin
                        res_d.addr   = base_eff;
                        res_d.wb_en  = 1'b1;
                        res_d.wb_val = moved;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign addr      = res_q.addr;
    assign wb_en     = res_q.wb_en;
    assign wb_val    = res_q.wb_val;
    assign annul     = res_q.annul;

    // R12: a rejected instruction never requests writeback
    a_r12_annul_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        annul |-> (!wb_en && addr == '0 && wb_val == '0));

    // R13: a result follows every accepted instruction
    a_r13_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R13: idle cycles hold the result fields
    a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(addr) && $stable(wb_val) && $stable(wb_en)));

    // R1: offset mode never writes the base
    a_r1_offset_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && p_bit && !w_bit) |=> !wb_en);

    // R2: pre-indexed writeback value equals the address
    a_r2_pre_wb_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && p_bit && w_bit) |=> (annul || (wb_en && wb_val == addr)));

    // R3: post-indexed address is the untouched base
    a_r3_post_addr_base: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !p_bit) |=> (annul || addr == $past(base_val)));

    // R6: writeback with the base on the program counter is rejected
    a_r6_pc_base_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(p_bit && !w_bit) && rn_idx == PC_CODE) |=> annul);

    // R11: halfword post form with writeback bit is rejected
    a_r11_half_post_w: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && half_form && !p_bit && w_bit) |=> annul);

endmodule

// File: tb/ls_addr_gen_tb.sv
module ls_addr_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        half_form, use_reg, p_bit, u_bit, w_bit;
    logic [3:0]  rn_idx, rd_idx, rm_idx;
    logic [31:0] base_val, rm_val;
    logic        carry_in;
    logic [11:0] imm12;
    logic [1:0]  sh_type;
    logic [4:0]  sh_amt;
    logic [3:0]  imm_hi, imm_lo;
    logic        out_valid, wb_en, annul;
    logic [31:0] addr, wb_val;

    int checks   = 0;
    int failures = 0;

    typedef struct {
        bit          half, use_reg, p, u, w;
        bit [3:0]    rn, rd, rm;
        bit [31:0]   base, rmv;
        bit          c;
        bit [11:0]   imm;
        bit [1:0]    sht;
        bit [4:0]    sha;
        bit [3:0]    hi, lo;
    } stim_t;

    typedef struct {
        bit        valid;
        bit [31:0] addr;
        bit        wb_en;
        bit [31:0] wb_val;
        bit        annul;
    } exp_t;

    exp_t exp_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    ls_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .half_form(half_form), .use_reg(use_reg), .p_bit(p_bit),
        .u_bit(u_bit), .w_bit(w_bit), .rn_idx(rn_idx), .rd_idx(rd_idx),
        .rm_idx(rm_idx), .base_val(base_val), .rm_val(rm_val),
        .carry_in(carry_in), .imm12(imm12), .sh_type(sh_type),
        .sh_amt(sh_amt), .imm_hi(imm_hi), .imm_lo(imm_lo),
        .out_valid(out_valid), .addr(addr), .wb_en(wb_en),
        .wb_val(wb_val), .annul(annul)
    );

    function automatic bit [31:0] ref_shift(bit [31:0] v, bit [1:0] k, bit [4:0] a, bit c);
        bit [63:0] dbl;
        int        sv;
        case (k)
            2'd0: return v << a;
            2'd1: return (a == 0) ? 32'h0 : (v >> a);
            2'd2: begin
                if (a == 0) return v[31] ? 32'hFFFF_FFFF : 32'h0;
                sv = int'(v);
                return 32'(sv >>> a);
            end
            default: begin
                if (a == 0) return {c, v[31:1]};
                dbl = {v, v} >> a;
                return dbl[31:0];
            end
        endcase
    endfunction

    function automatic exp_t model(stim_t s);
        exp_t      e;
        bit [31:0] off, b, moved;
        bit        writes, bad;
        e = '{valid: 1'b1, addr: 32'h0, wb_en: 1'b0, wb_val: 32'h0, annul: 1'b0};
        if (s.half) off = s.use_reg ? s.rmv : {24'h0, s.hi, s.lo};
        else        off = s.use_reg ? ref_shift(s.rmv, s.sht, s.sha, s.c) : {20'h0, s.imm};
        writes = !(s.p && !s.w);
        bad = 0;
        if (s.half && !s.p && s.w) bad = 1;
        if (writes && (s.rn == 15 || s.rn == s.rd)) bad = 1;
        if (writes && s.use_reg && (s.rm == 15 || s.rn == s.rm)) bad = 1;
        if (bad) begin
            e.annul = 1;
            return e;
        end
        b = s.base;
        if (!writes && s.rn == 15) b = b + 32'd4;
        moved = s.u ? b + off : b - off;
        if (s.p) begin
            e.addr = moved;
            if (s.w) begin
                e.wb_en  = 1;
                e.wb_val = moved;
            end
        end else begin
            e.addr   = b;
            e.wb_en  = 1;
            e.wb_val = moved;
        end
        return e;
    endfunction

    task automatic check(input string tag, input string what, input bit [31:0] act, input bit [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "out_valid", {31'h0, out_valid}, {31'h0, exp_q.valid});
        check(tag, "addr",      addr,               exp_q.addr);
        check(tag, "wb_en",     {31'h0, wb_en},     {31'h0, exp_q.wb_en});
        check(tag, "wb_val",    wb_val,             exp_q.wb_val);
        check(tag, "annul",     {31'h0, annul},     {31'h0, exp_q.annul});
    endtask

    function automatic stim_t base_stim();
        stim_t s;
        s.half = 0; s.use_reg = 0; s.p = 1; s.u = 1; s.w = 0;
        s.rn = 4'd1; s.rd = 4'd2; s.rm = 4'd3;
        s.base = 32'h0000_1000; s.rmv = 32'h0000_0010; s.c = 0;
        s.imm = 12'h020; s.sht = 2'd0; s.sha = 5'd0; s.hi = 4'h0; s.lo = 4'h0;
        return s;
    endfunction

    task automatic apply(input stim_t s, input string tag);
        half_form = s.half; use_reg = s.use_reg; p_bit = s.p; u_bit = s.u; w_bit = s.w;
        rn_idx = s.rn; rd_idx = s.rd; rm_idx = s.rm;
        base_val = s.base; rm_val = s.rmv; carry_in = s.c;
        imm12 = s.imm; sh_type = s.sht; sh_amt = s.sha; imm_hi = s.hi; imm_lo = s.lo;
        in_valid = 1'b1;
        @(negedge clk);
        exp_q = model(s);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        in_valid = 1'b0;
        base_val = 32'hDEAD_BEEF;
        @(negedge clk);
        exp_q.valid = 0;
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        stim_t s;
        rst_n = 0; in_valid = 0;
        half_form = 0; use_reg = 0; p_bit = 0; u_bit = 0; w_bit = 0;
        rn_idx = 0; rd_idx = 0; rm_idx = 0; base_val = 0; rm_val = 0;
        carry_in = 0; imm12 = 0; sh_type = 0; sh_amt = 0; imm_hi = 0; imm_lo = 0;
        repeat (3) @(negedge clk);
        exp_q = '{valid: 1'b0, addr: 32'h0, wb_en: 1'b0, wb_val: 32'h0, annul: 1'b0};
        compare("R14");
        rst_n = 1;

        // R1 and R4: offset mode, add then subtract
        s = base_stim(); apply(s, "R1");
        s.u = 0; apply(s, "R4");
        // R2: pre-indexed
        s = base_stim(); s.w = 1; apply(s, "R2");
        s.u = 0; apply(s, "R2");
        // R3: post-indexed, word form ignores w_bit
        s = base_stim(); s.p = 0; apply(s, "R3");
        s.w = 1; apply(s, "R3");
        // R5: base on program counter in offset mode
        s = base_stim(); s.rn = 15; s.base = 32'h100; s.imm = 12'h008; apply(s, "R5");
        s.u = 0; apply(s, "R5");
        // R6 and R12: base clashes in writeback forms
        s = base_stim(); s.w = 1; s.rn = 4'd5; s.rd = 4'd5; apply(s, "R6");
        s = base_stim(); s.p = 0; s.rn = 15; apply(s, "R12");
        // R7: register offset clashes
        s = base_stim(); s.use_reg = 1; s.w = 1; s.rm = s.rn; apply(s, "R7");
        s = base_stim(); s.use_reg = 1; s.p = 0; s.rm = 15; apply(s, "R7");
        s = base_stim(); s.half = 1; s.use_reg = 1; s.p = 0; s.rm = 4'd1; apply(s, "R7");
        s = base_stim(); s.use_reg = 1; s.rm = 4'd1; apply(s, "R7");
        // R8: nonzero shift amounts
        s = base_stim(); s.use_reg = 1; s.rmv = 32'h8000_00F1;
        s.sht = 0; s.sha = 5'd3;  apply(s, "R8");
        s.sht = 1; s.sha = 5'd4;  apply(s, "R8");
        s.sht = 2; s.sha = 5'd4;  apply(s, "R8");
        s.sht = 3; s.sha = 5'd8;  apply(s, "R8");
        s.sht = 3; s.sha = 5'd31; apply(s, "R8");
        // R9: zero shift amount meanings
        s.sha = 5'd0;
        s.sht = 0; apply(s, "R9");
        s.sht = 1; apply(s, "R9");
        s.sht = 2; apply(s, "R9");
        s.rmv = 32'h7000_0003; apply(s, "R9");
        s.sht = 3; s.c = 1; apply(s, "R9");
        s.c = 0; apply(s, "R9");
        // R10: halfword offsets
        s = base_stim(); s.half = 1; s.hi = 4'hA; s.lo = 4'h5; apply(s, "R10");
        s.use_reg = 1; s.rmv = 32'h0000_0333; s.sht = 1; s.sha = 5'd0; apply(s, "R10");
        // R11: halfword post form with writeback bit
        s = base_stim(); s.half = 1; s.p = 0; s.w = 1; apply(s, "R11");
        s.w = 0; apply(s, "R11");
        // R13: idle cycles hold
        s = base_stim(); s.w = 1; apply(s, "R13");
        idle("R13");
        idle("R13");

        // R13: random stream, indices folded so they collide
        for (int i = 0; i < 600; i++) begin
            s.half = 1'($urandom); s.use_reg = 1'($urandom);
            s.p = 1'($urandom); s.u = 1'($urandom); s.w = 1'($urandom);
            s.rn = 4'($urandom_range(12, 15)); s.rd = 4'($urandom_range(12, 15));
            s.rm = 4'($urandom_range(12, 15));
            s.base = $urandom; s.rmv = $urandom; s.c = 1'($urandom);
            s.imm = 12'($urandom); s.sht = 2'($urandom); s.sha = 5'($urandom_range(0, 3) == 0 ? 0 : $urandom);
            s.hi = 4'($urandom); s.lo = 4'($urandom);
            if ($urandom_range(0, 4) == 0) idle("R13");
            else apply(s, "R13");
        end

        in_valid = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule